// File: doc/BRIEF.md
# Link Frequency Shadow Register Controller

This block keeps two 4-bit link frequency codes. Software reads and writes the visible code. The shadow code is the one actually sent to the link clock generator. A write from software changes only the visible code, so the clock generator keeps running at its old rate. The new rate takes effect only when a warm link reset copies the visible code into the shadow.

A mode flag, stored in the block and set through the same write port, selects between two behaviours. With the flag clear (the default), link resets follow the current standard: a cold link reset returns both codes to the base-rate code, and a warm link reset loads the shadow from the visible code. With the flag set, the block behaves like older fixed-frequency parts: link resets change neither code.

A system reset returns both codes and the mode flag to their defaults. This reset is asserted asynchronously and released synchronously. Once the synchronised reset is released, the block responds to its inputs from the next clock edge.

Top module: `lfreq_shadow_ctrl`

## Requirements
- R1: While the system reset is asserted, and after it is released, both codes read 4'h0 (the base-rate code) and the mode flag is clear. A clear mode flag means standard behaviour.
- R2: A write with `wr_sel`=0 while neither link reset pulse is high loads `wr_data` into the visible code one clock later. The same write leaves the shadow code unchanged.
- R3: A cold link pulse with the mode flag clear sets both codes to 4'h0 one clock later.
- R4: A cold link pulse with the mode flag set leaves both codes unchanged.
- R5: A warm link pulse (with no cold pulse) and the mode flag clear loads the shadow code with the visible code's value from before the edge. The visible code keeps its value.
- R6: A warm link pulse with the mode flag set leaves both codes unchanged.
- R7: A write with `wr_sel`=1 while neither pulse is high sets the mode flag to `wr_data[0]`. Bits 3:1 of `wr_data` are ignored, and neither code changes.
- R8: A write in the same cycle as a cold or warm pulse is dropped, whichever register it targets.
- R9: When cold and warm pulses arrive in the same cycle, only the cold rule applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low; asserts asynchronously and is released synchronously |
| cold_pulse | input | 1 | Single-cycle cold link reset event |
| warm_pulse | input | 1 | Single-cycle warm link reset event |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 selects the visible frequency code, 1 selects the mode flag (data bit 0) |
| wr_data | input | 4 | Write data |
| vis_freq | output | 4 | Software-visible frequency code |
| pll_freq | output | 4 | Shadow frequency code sent to the clock generator |

## Verification
The in-line assertions check the per-cycle update rules on every cycle:
- a write lands in the visible code and not in the shadow;
- a cold or warm pulse in standard mode clears both codes or copies the visible code into the shadow;
- link pulses in legacy mode leave both codes alone;
- a write that collides with a pulse is suppressed.

Some behaviours only the bench's scenarios can show:
- The mode flag is internal, so its reset value and the masking of write bits 3:1 are seen only through a later warm pulse.
- Cold-over-warm priority needs visible and shadow codes that differ beforehand.
- The asynchronous return to defaults during a mid-run system reset is checked by directed sequences.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic {
    SEL_FREQ = 1'b0,
    SEL_MODE = 1'b1
  } lfs_sel_e;

  typedef struct packed {
    logic clr_codes;
    logic copy_shadow;
    logic wr_freq;
    logic wr_mode;
  } lfs_act_t;
endpackage

// File: rtl/lfs_rst_sync.sv
module lfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_nxt = 1'b1;
    end else begin : g_many
      always_comb chain_nxt = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lfs_event_arb.sv
module lfs_event_arb
  import lfs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cold,
  input  logic     warm,
  input  logic     wr_en,
  input  logic     wr_sel,
  input  logic     legacy,
  output lfs_act_t act
);
  logic link_evt;

  always_comb begin
    link_evt        = cold | warm;
    act.clr_codes   = cold & ~legacy;
    act.copy_shadow = warm & ~cold & ~legacy;
    act.wr_freq     = wr_en & ~link_evt & (lfs_sel_e'(wr_sel) == SEL_FREQ);
    act.wr_mode     = wr_en & ~link_evt & (lfs_sel_e'(wr_sel) == SEL_MODE);
  end

  // R8: a link event always suppresses register writes
  assert_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cold || warm) |-> !(act.wr_freq || act.wr_mode));

  // R9: cold outranks warm
  assert_cold_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cold |-> !act.copy_shadow);
endmodule

// File: rtl/lfs_code_reg.sv
module lfs_code_reg #(
  parameter int              W       = 4,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         en;
  logic         armed_q;

  always_comb begin
    en    = clear | load;
    q_nxt = q;
    if (clear)     q_nxt = RST_VAL;
    else if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (en) q <= q_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R2 (visible instance) / R5 (shadow instance): a load lands next cycle
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (!armed_q)
    $past(load && !clear) |-> q == $past(d));

  // R3: a clear returns the default
  assert_clear_lands_R3: assert property (@(posedge clk) disable iff (!armed_q)
    $past(clear) |-> q == RST_VAL);
endmodule

// File: rtl/lfreq_shadow_ctrl.sv
module lfreq_shadow_ctrl
  import lfs_pkg::*;
#(
  parameter int                  FREQ_W      = 4,
  parameter logic [FREQ_W-1:0]   FREQ_BASE   = '0,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cold_pulse,
  input  logic              warm_pulse,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [FREQ_W-1:0] wr_data,
  output logic [FREQ_W-1:0] vis_freq,
  output logic [FREQ_W-1:0] pll_freq
);
  logic     rst_sync_n;
  lfs_act_t act;
  logic     legacy_q;
  logic     legacy_nxt;
  logic     armed_q;

  lfs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lfs_event_arb u_arb (
    .clk(clk), .rst_n(rst_sync_n),
    .cold(cold_pulse), .warm(warm_pulse),
    .wr_en(wr_en), .wr_sel(wr_sel),
    .legacy(legacy_q), .act(act)
  );

  lfs_code_reg #(.W(FREQ_W), .RST_VAL(FREQ_BASE)) u_vis (
    .clk(clk), .rst_n(rst_sync_n),
    .clear(act.clr_codes), .load(act.wr_freq),
    .d(wr_data), .q(vis_freq)
  );

  lfs_code_reg #(.W(FREQ_W), .RST_VAL(FREQ_BASE)) u_pll (
    .clk(clk), .rst_n(rst_sync_n),
    .clear(act.clr_codes), .load(act.copy_shadow),
    .d(vis_freq), .q(pll_freq)
  );

  always_comb begin
    legacy_nxt = legacy_q;
    if (act.wr_mode) legacy_nxt = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)      legacy_q <= 1'b0;
    else if (act.wr_mode) legacy_q <= legacy_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed_q <= 1'b0;
    else             armed_q <= 1'b1;
  end

  assert_reset_default_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (vis_freq == FREQ_BASE && pll_freq == FREQ_BASE));

  assert_write_vis_only_R2: assert property (@(posedge clk) disable iff (!armed_q)
    $past(wr_en && !wr_sel && !cold_pulse && !warm_pulse)
      |-> (vis_freq == $past(wr_data) && $stable(pll_freq)));

  assert_cold_std_R3: assert property (@(posedge clk) disable iff (!armed_q)
    $past(cold_pulse && !legacy_q) |-> (vis_freq == FREQ_BASE && pll_freq == FREQ_BASE));

  assert_cold_legacy_R4: assert property (@(posedge clk) disable iff (!armed_q)
    $past(cold_pulse && legacy_q) |-> ($stable(vis_freq) && $stable(pll_freq)));

  assert_warm_std_R5: assert property (@(posedge clk) disable iff (!armed_q)
    $past(warm_pulse && !cold_pulse && !legacy_q)
      |-> (pll_freq == $past(vis_freq) && $stable(vis_freq)));

  assert_warm_legacy_R6: assert property (@(posedge clk) disable iff (!armed_q)
    $past(warm_pulse && legacy_q) |-> ($stable(vis_freq) && $stable(pll_freq)));

  assert_mode_write_R7: assert property (@(posedge clk) disable iff (!armed_q)
    $past(wr_en && wr_sel && !cold_pulse && !warm_pulse)
      |-> ($stable(vis_freq) && $stable(pll_freq)));
endmodule

// File: tb/lfreq_shadow_ctrl_tb.sv
module lfreq_shadow_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cold_pulse, warm_pulse, wr_en, wr_sel;
  logic [3:0] wr_data;
  logic [3:0] vis_freq, pll_freq;

  int n_cmp = 0;
  int n_bad = 0;

  logic [3:0] m_vis, m_pll;
  logic       m_leg;

  always #2 clk = ~clk;

  lfreq_shadow_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cold_pulse(cold_pulse), .warm_pulse(warm_pulse),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vis_freq(vis_freq), .pll_freq(pll_freq)
  );

  task automatic check(input string tag, input string what,
                       input logic [3:0] got, input logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic string pick_tag(input logic c, input logic w,
                                     input logic we, input logic sel);
    if (c && w) return "R9";
    if (c)      return m_leg ? "R4" : "R3";
    if (w)      return m_leg ? "R6" : "R5";
    if (we)     return sel ? "R7" : "R2";
    return "R2";
  endfunction

  task automatic step(input logic c, input logic w, input logic we,
                      input logic sel, input logic [3:0] d, input string tag);
    string t;
    @(negedge clk);
    cold_pulse = c; warm_pulse = w; wr_en = we; wr_sel = sel; wr_data = d;
    t = (tag == "") ? pick_tag(c, w, we, sel) : tag;
    @(posedge clk);
    if (c) begin
      if (!m_leg) begin m_vis = 4'h0; m_pll = 4'h0; end
    end else if (w) begin
      if (!m_leg) m_pll = m_vis;
    end else if (we) begin
      if (!sel) m_vis = d;
      else      m_leg = d[0];
    end
    @(negedge clk);
    cold_pulse = 1'b0; warm_pulse = 1'b0; wr_en = 1'b0;
    check(t, "vis_freq", vis_freq, m_vis);
    check(t, "pll_freq", pll_freq, m_pll);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_vis = 4'h0; m_pll = 4'h0; m_leg = 1'b0;
    #1;
    check("R1", "vis_freq in reset", vis_freq, 4'h0);
    check("R1", "pll_freq in reset", pll_freq, 4'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "vis_freq after reset", vis_freq, 4'h0);
    check("R1", "pll_freq after reset", pll_freq, 4'h0);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed_r;
    cold_pulse = 0; warm_pulse = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    rst_n = 1'b1;
    seed_r = $urandom(32'd1207);
    do_reset();

    step(0, 0, 1, 0, 4'h5, "R2");
    step(0, 1, 0, 0, 4'h0, "R5");
    step(0, 0, 1, 0, 4'h9, "R2");
    step(1, 0, 0, 0, 4'h0, "R3");
    step(0, 0, 1, 0, 4'h3, "R2");
    step(0, 0, 1, 1, 4'hE, "R7");       // bit0=0: mode stays standard
    step(0, 1, 0, 0, 4'h0, "R7");       // copy proves standard mode
    step(0, 0, 1, 1, 4'h1, "R7");       // legacy mode on
    step(0, 0, 1, 0, 4'h7, "R2");
    step(0, 1, 0, 0, 4'h0, "R6");
    step(1, 0, 0, 0, 4'h0, "R4");
    step(0, 0, 1, 1, 4'h0, "R7");       // back to standard
    step(0, 0, 1, 0, 4'h6, "R2");
    step(1, 1, 0, 0, 4'h0, "R9");       // vis 6, pll 3 before: cold wins
    step(0, 0, 1, 0, 4'h2, "R2");
    step(0, 1, 1, 0, 4'h8, "R8");       // write dropped, pll gets 2
    step(1, 0, 1, 1, 4'h1, "R8");       // mode write dropped
    step(0, 0, 1, 0, 4'hA, "R2");
    step(0, 1, 0, 0, 4'h0, "R8");       // copy proves mode still standard

    step(0, 0, 1, 1, 4'h1, "R7");
    step(0, 0, 1, 0, 4'hC, "R2");
    do_reset();
    step(0, 0, 1, 0, 4'h5, "R1");
    step(0, 1, 0, 0, 4'h0, "R1");       // standard mode after system reset

    for (int i = 0; i < 3000; i++) begin
      logic c, w, we, sel;
      logic [3:0] d;
      c   = ($urandom_range(0, 9) == 0);
      w   = ($urandom_range(0, 5) == 0);
      we  = ($urandom_range(0, 2) != 0);
      sel = ($urandom_range(0, 7) == 0);
      d   = 4'($urandom_range(0, 15));
      step(c, w, we, sel, d, "");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule